// File: doc/BRIEF.md
# Prescaled Up/Down Alarm Timer

This block is a general-purpose hardware timer. A programmable prescaler turns the system clock into count ticks. A 54-bit time base steps on each tick, either upward or downward, and software picks the direction. Counting runs only while the run enable is high. Dropping the enable freezes both the count and the prescaler phase, so a later resume carries on from where it stopped. A load strobe forces the reload value into the count at once.

An armed alarm compares the count with a programmable value. On a match the block raises a level interrupt, and the interrupt stays high until software clears it. Each arming yields one alarm, because the arm bit drops when the alarm fires. When auto-reload is on, the tick after the alarm puts the reload value into the count in place of the normal step. The count is read through a snapshot register that a latch strobe fills, so all 54 bits are captured in the same cycle.

All control inputs are sampled on the rising clock edge. The strobes act in each cycle they are high. Clock source selection and bus bridging are left to the surrounding logic.

Top module: `gp_alarm_timer`

## Requirements
- R1: Reset state:
  - While `rst_n` is low, the count, the prescaler phase and the snapshot are all zero.
  - The interrupt is low, the alarm is disarmed and no reload is pending.
- R2: Tick spacing:
  - With `run_en` held high, a `div_val` of N (1 to 65535) gives one count tick every N clocks.
  - A `div_val` of 0 gives one tick every 65536 clocks.
- R3: Direction and wrap:
  - Each tick adds one to the count when `count_up` is 1 and subtracts one when it is 0.
  - The count wraps modulo 2^54, so the all-ones value steps up to zero and zero steps down to all ones.
- R4: Halt and resume:
  - While `run_en` is low, the count and the prescaler phase hold their values.
  - After a resume, the next tick comes when the remaining part of the interrupted period has elapsed.
- R5: Load strobe:
  - `load_stb` writes `reload_val` into the count on the next edge, whatever the state of `run_en`.
  - It also restarts the prescaler phase and cancels any pending reload.
  - It takes priority over a tick in the same cycle.
- R6: Snapshot:
  - `latch_stb` copies the count, as it stood before the edge, into `snap_cnt`.
  - `snap_cnt` holds its value in every cycle without a strobe.
- R7: Alarm:
  - A pulse on `alarm_arm` arms the alarm.
  - While armed, a count equal to `alarm_val` raises `irq` one clock later and disarms the alarm.
  - A later return to the same count raises no further interrupt until the alarm is armed again.
- R8: Interrupt hold and clear:
  - `irq` stays high until a cycle with `irq_clr` high, and it is low after that edge.
  - When an alarm and `irq_clr` fall in the same cycle, the alarm wins and `irq` stays high.
- R9: Auto-reload:
  - When `autoreload_en` is high at the alarm, the first tick after the alarm loads `reload_val` in place of the normal step.
  - Ticks without an earlier alarm never reload.
- R10: No auto-reload: when `autoreload_en` is low at the alarm, the count keeps stepping past the alarm value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Counting enable; low halts the count and the prescaler phase |
| count_up | input | 1 | Counting direction: 1 counts up, 0 counts down |
| div_val | input | 16 | Prescaler divider; 0 divides by 65536 |
| reload_val | input | 54 | Value taken by the load strobe and by auto-reload |
| load_stb | input | 1 | Writes `reload_val` into the count |
| alarm_val | input | 54 | Alarm compare value |
| alarm_arm | input | 1 | Arms the alarm |
| autoreload_en | input | 1 | Turns on reload at the tick after an alarm |
| irq_clr | input | 1 | Clears the interrupt |
| latch_stb | input | 1 | Copies the live count into the snapshot |
| snap_cnt | output | 54 | Snapshot of the count |
| irq | output | 1 | Level alarm interrupt |

## Verification
The assertions assume that every control input is synchronous to `clk` and never X once reset has been released. They also assume that `reload_val` and `alarm_val` are stable whenever a strobe or a match could sample them. The bench keeps within these limits by changing inputs only one nanosecond after a rising edge, in whole-cycle steps. It moves the compare and reload values only while no alarm or reload can occur. A behavioural model follows the same input stream and is compared with `irq` and `snap_cnt` on every clock. Directed checks add fixed expected counts for the divider boundaries, wrap in both directions, halt in the middle of a period, and an alarm that meets a clear in the same cycle.

// File: rtl/tmr_pkg.sv
// Package: shared defaults and the direction encoding for the alarm timer.
// Assumes nothing beyond standard SystemVerilog.
package tmr_pkg;
    localparam int unsigned CNT_W_DEF = 54;
    localparam int unsigned DIV_W_DEF = 16;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Divides the clock into count ticks. A divider of N gives one tick every N
// enabled clocks, and a divider of zero means the full 2^DIV_W range.
// Assumes div_val is stable over a period; if it is lowered below the
// current phase, the next enabled clock ticks.
module tmr_prescaler #(
    parameter int unsigned DIV_W = tmr_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] term;

    // Last phase value of a period (zero divider maps to all ones).
    always_comb term = (div_val == '0) ? '1 : (div_val - DIV_W'(1));

    assign tick = run_en && (phase_q >= term);

    // Phase counter: restart on load, wrap on tick, hold while halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || tick) begin
            phase_q <= '0;
        end else if (run_en) begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// The wide time base. Loads on a strobe, reloads on the first tick after an
// auto-reload alarm, and otherwise steps by one in the chosen direction.
// Assumes tick and load_stb are synchronous single-clock qualifiers.
module tmr_counter #(
    parameter int unsigned CNT_W = tmr_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_stb,
    input  logic             reload_pend,
    input  tmr_pkg::dir_e    dir,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q
);
    logic [CNT_W-1:0] stepped;

    // One step in the selected direction, wrapping modulo 2^CNT_W.
    always_comb begin
        if (dir == tmr_pkg::DIR_UP) stepped = count_q + CNT_W'(1);
        else                        stepped = count_q - CNT_W'(1);
    end

    // Count register: the load strobe beats a tick, a pending reload beats a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_stb) begin
            count_q <= reload_val;
        end else if (tick) begin
            count_q <= reload_pend ? reload_val : stepped;
        end
    end
endmodule

// File: rtl/tmr_alarm.sv
// Module: tmr_alarm
// Holds the arm bit, the reload-pending flag and the level interrupt.
// A match while armed fires once, disarms, and may request a reload.
// Assumes alarm_val is stable around the expected match.
module tmr_alarm #(
    parameter int unsigned CNT_W = tmr_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic             arm_stb,
    input  logic             autoreload_en,
    input  logic             tick,
    input  logic             load_stb,
    input  logic             irq_clr,
    output logic             alarm_hit,
    output logic             reload_pend,
    output logic             irq
);
    logic arm_q;
    logic pend_q;
    logic irq_q;

    assign alarm_hit   = arm_q && (count_q == alarm_val);
    assign reload_pend = pend_q;
    assign irq         = irq_q;

    // Arm bit: set by software, dropped by the alarm it produces.
    always_ff @(posedge clk) begin
        if (!rst_n)         arm_q <= 1'b0;
        else if (arm_stb)   arm_q <= 1'b1;
        else if (alarm_hit) arm_q <= 1'b0;
    end

    // Reload request: raised by an auto-reload alarm, consumed by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend_q <= 1'b0;
        else if (load_stb)                   pend_q <= 1'b0;
        else if (alarm_hit && autoreload_en) pend_q <= 1'b1;
        else if (tick)                       pend_q <= 1'b0;
    end

    // Level interrupt: set by an alarm, cleared by software; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (alarm_hit) irq_q <= 1'b1;
        else if (irq_clr)   irq_q <= 1'b0;
    end
endmodule

// File: rtl/gp_alarm_timer.sv
// Module: gp_alarm_timer
// Top of the timer: prescaler, time base, alarm unit and the snapshot
// register used to read the count coherently.
// Assumes every input is synchronous to clk.
module gp_alarm_timer #(
    parameter int unsigned CNT_W = tmr_pkg::CNT_W_DEF,
    parameter int unsigned DIV_W = tmr_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             count_up,
    input  logic [DIV_W-1:0] div_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic             alarm_arm,
    input  logic             autoreload_en,
    input  logic             irq_clr,
    input  logic             latch_stb,
    output logic [CNT_W-1:0] snap_cnt,
    output logic             irq
);
    logic             tick;
    logic             alarm_hit;
    logic             reload_pend;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] snap_q;
    tmr_pkg::dir_e    dir;

    assign dir      = count_up ? tmr_pkg::DIR_UP : tmr_pkg::DIR_DOWN;
    assign snap_cnt = snap_q;

    tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .restart (load_stb),
        .div_val (div_val),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .load_stb    (load_stb),
        .reload_pend (reload_pend),
        .dir         (dir),
        .reload_val  (reload_val),
        .count_q     (count_q)
    );

    tmr_alarm #(.CNT_W(CNT_W)) u_alm (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_q       (count_q),
        .alarm_val     (alarm_val),
        .arm_stb       (alarm_arm),
        .autoreload_en (autoreload_en),
        .tick          (tick),
        .load_stb      (load_stb),
        .irq_clr       (irq_clr),
        .alarm_hit     (alarm_hit),
        .reload_pend   (reload_pend),
        .irq           (irq)
    );

    // Snapshot register: captures the live count on a latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (latch_stb) snap_q <= count_q;
    end
endmodule

// File: rtl/gp_alarm_timer_chk.sv
// Module: gp_alarm_timer_chk
// Checker bound into gp_alarm_timer; relates ports and internal state over time.
module gp_alarm_timer_chk #(
    parameter int unsigned CNT_W = tmr_pkg::CNT_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             count_up,
    input logic             load_stb,
    input logic             latch_stb,
    input logic             irq_clr,
    input logic             tick,
    input logic             alarm_hit,
    input logic             reload_pend,
    input logic             irq,
    input logic [CNT_W-1:0] reload_val,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] snap_cnt
);
    // R2: no tick reaches the counter while halted.
    a_r2_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run_en);

    // R3: an up tick without load or pending reload adds exactly one.
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_up && !load_stb && !reload_pend)
        |=> count_q == ($past(count_q) + CNT_W'(1)));

    // R4: a halted counter keeps its value when nothing loads it.
    a_r4_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_stb) |=> $stable(count_q));

    // R5: the load strobe lands the reload value.
    a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> count_q == $past(reload_val));

    // R6: the snapshot takes the count seen at the strobe.
    a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> snap_cnt == $past(count_q));

    // R7: an alarm raises the interrupt one clock later.
    a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> irq);

    // R8: the interrupt holds without a clear.
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R8: a clear with no competing alarm drops the interrupt.
    a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !alarm_hit) |=> !irq);
endmodule

bind gp_alarm_timer gp_alarm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .count_up    (count_up),
    .load_stb    (load_stb),
    .latch_stb   (latch_stb),
    .irq_clr     (irq_clr),
    .tick        (tick),
    .alarm_hit   (alarm_hit),
    .reload_pend (reload_pend),
    .irq         (irq),
    .reload_val  (reload_val),
    .count_q     (count_q),
    .snap_cnt    (snap_cnt)
);

// File: tb/gp_alarm_timer_tb.sv
`timescale 1ns/1ps
// Bench: behavioural model compared on every clock plus directed checks.
module gp_alarm_timer_tb;
    localparam int CW = 54;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0, count_up = 1'b1, load_stb = 1'b0;
    logic          alarm_arm = 1'b0, autoreload_en = 1'b0, irq_clr = 1'b0, latch_stb = 1'b0;
    logic [DW-1:0] div_val = '0;
    logic [CW-1:0] reload_val = '0, alarm_val = '0;
    logic [CW-1:0] snap_cnt;
    logic          irq;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    gp_alarm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .count_up(count_up),
        .div_val(div_val), .reload_val(reload_val), .load_stb(load_stb),
        .alarm_val(alarm_val), .alarm_arm(alarm_arm), .autoreload_en(autoreload_en),
        .irq_clr(irq_clr), .latch_stb(latch_stb), .snap_cnt(snap_cnt), .irq(irq)
    );

    // Behavioural reference model.
    int            m_pre;
    logic [CW-1:0] m_cnt, m_snap;
    logic          m_arm, m_pend, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = '0; m_snap = '0; m_arm = 0; m_pend = 0; m_irq = 0;
        end else begin
            int lim;
            logic tk, hit;
            lim = (div_val == 0) ? 65536 : int'(div_val);
            tk  = run_en && (m_pre >= lim - 1);
            hit = m_arm && (m_cnt == alarm_val);
            if (latch_stb) m_snap = m_cnt;
            if (load_stb) m_pre = 0;
            else if (tk) m_pre = 0;
            else if (run_en) m_pre = m_pre + 1;
            if (load_stb) m_cnt = reload_val;
            else if (tk) m_cnt = m_pend ? reload_val : (count_up ? m_cnt + 1 : m_cnt - 1);
            if (load_stb) m_pend = 0;
            else if (hit && autoreload_en) m_pend = 1;
            else if (tk) m_pend = 0;
            if (alarm_arm) m_arm = 1;
            else if (hit) m_arm = 0;
            if (hit) m_irq = 1;
            else if (irq_clr) m_irq = 0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            chk({cur_tag, " model irq"}, 64'(irq), 64'(m_irq));
            chk({cur_tag, " model snap"}, 64'(snap_cnt), 64'(m_snap));
        end
    endtask

    task automatic do_load(input logic [CW-1:0] v);
        reload_val = v; load_stb = 1'b1; cyc(1); load_stb = 1'b0;
    endtask

    task automatic do_latch();
        latch_stb = 1'b1; cyc(1); latch_stb = 1'b0;
    endtask

    task automatic run(input int n);
        run_en = 1'b1; cyc(n); run_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 irq after reset", 64'(irq), 64'd0);
        chk("R1 snap after reset", 64'(snap_cnt), 64'd0);

        cur_tag = "R5";
        do_load(54'd100);
        do_latch();
        chk("R5 load while halted", 64'(snap_cnt), 64'd100);

        cur_tag = "R2";
        div_val = 16'd3;
        run(9);
        do_latch();
        chk("R2 divide by 3", 64'(snap_cnt), 64'd103);

        cur_tag = "R4";
        run(2); cyc(5); run(1);
        do_latch();
        chk("R4 resume keeps phase", 64'(snap_cnt), 64'd104);

        cur_tag = "R3";
        div_val = 16'd1; count_up = 1'b0;
        do_load('0); run(1); do_latch();
        chk("R3 down wrap", 64'(snap_cnt), 64'h3F_FFFF_FFFF_FFFF);
        count_up = 1'b1;
        do_load('1); run(1); do_latch();
        chk("R3 up wrap", 64'(snap_cnt), 64'd0);

        cur_tag = "R2";
        div_val = 16'd0;
        do_load('0); run(65535); do_latch();
        chk("R2 zero divider before period end", 64'(snap_cnt), 64'd0);
        run(1); do_latch();
        chk("R2 zero divider one tick", 64'(snap_cnt), 64'd1);

        cur_tag = "R9";
        div_val = 16'd1; alarm_val = 54'd13; autoreload_en = 1'b1;
        do_load(54'd10);
        reload_val = 54'd500;
        alarm_arm = 1'b1; cyc(1); alarm_arm = 1'b0;
        run(3);
        chk("R7 no irq in match cycle", 64'(irq), 64'd0);
        run(1);
        chk("R7 irq after match", 64'(irq), 64'd1);
        run(1);
        do_latch();
        chk("R9 reload on tick after alarm", 64'(snap_cnt), 64'd500);

        cur_tag = "R8";
        cyc(20);
        chk("R8 irq held", 64'(irq), 64'd1);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        chk("R8 irq cleared", 64'(irq), 64'd0);

        cur_tag = "R7";
        reload_val = 54'd10; do_load(54'd10);
        run(10);
        chk("R7 disarmed after alarm", 64'(irq), 64'd0);
        do_latch();
        chk("R9 no reload without alarm", 64'(snap_cnt), 64'd20);

        cur_tag = "R10";
        autoreload_en = 1'b0;
        do_load(54'd10);
        alarm_arm = 1'b1; cyc(1); alarm_arm = 1'b0;
        run(6);
        chk("R10 irq raised", 64'(irq), 64'd1);
        do_latch();
        chk("R10 steps past alarm", 64'(snap_cnt), 64'd16);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;

        cur_tag = "R8";
        do_load(54'd12);
        alarm_arm = 1'b1; cyc(1); alarm_arm = 1'b0;
        run(1);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        chk("R8 alarm beats clear", 64'(irq), 64'd1);
        cyc(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule